// File: doc/BRIEF.md
# Real-Time Clock Counter Chain

This block keeps time with two cascaded counters. A prescaler, 15 bits wide by default, advances on every clock in which the clock is running and the `tick_en` input is high. Each time the prescaler wraps from all ones to zero, a free-running counter, 32 bits wide by default, advances by one and a tick flag sets. Software reaches the block through a small register bus with a single-cycle write strobe and a combinational read path. Through this bus it reads both counters, starts or stops the chain, programs an interrupt level and manages the tick flag.

Both counters are normally read-only. To load new values, software arms a one-shot write-enable latch, writes the full counter and then writes the prescaler. The write to the prescaler closes the latch. The sequencer has three states. `WE_CLOSED` moves to `WE_ARMED` on an arm request. `WE_ARMED` moves to `WE_COUNT_DONE` on a counter write. `WE_COUNT_DONE` moves back to `WE_CLOSED` on a prescaler write. Any other event leaves the state unchanged.

The tick flag clears only under a guarded rule, which a second state machine tracks. `FLG_UNSEEN` moves to `FLG_SEEN` when the control register is read while the flag is set. `FLG_SEEN` returns to `FLG_UNSEEN` on a clearing write, which then clears the flag. Any counter increment returns that machine to `FLG_UNSEEN` and sets the flag again. A set flag raises an interrupt at the programmed level. The block also presents a 4-bit arbitration number for that request.

Top module: `rtc_chain`

Register addresses:
- Address 0 is control.
- Address 1 is the counter.
- Address 2 is the prescaler, zero-extended on read.
- Address 3 reads zero.

Control bits:
- Bit 0: run.
- Bit 1: arm.
- Bit 2: tick flag.
- Bits 6:4: interrupt level.
- Bit 7: arbitration bit 3.

## Requirements
- R1: The prescaler advances by one on each clock with run (control bit 0) = 1 and `tick_en` = 1. With either one low it holds its value.
- R2: When the prescaler advances from all ones, it wraps to zero, the counter advances by one (modulo 2^32) and the tick flag (control bit 2) sets.
- R3: A write to the counter (address 1) or to the prescaler (address 2) while the sequencer is in `WE_CLOSED` has no effect.
- R4: After an arm request (a control write with bit 1 = 1), a counter write loads the counter and a following prescaler write loads the prescaler. That prescaler write closes the latch, so later counter or prescaler writes are ignored.
- R5: A prescaler write in `WE_ARMED`, before any counter write, is ignored and leaves the latch armed. An arm request in `WE_ARMED` or `WE_COUNT_DONE` is ignored.
- R6: Control bit 1 always reads as zero. Bit 0 reads back run, bits 6:4 read back the level, bit 7 reads back arbitration bit 3 and bit 2 reads the tick flag.
- R7: A control write with bit 2 = 0 clears the tick flag only if an earlier control read saw the flag set. Without such a read the flag stays set. A control write with bit 2 = 1 never changes the flag.
- R8: A clearing write is rejected, and the flag stays set, if the counter advanced between the control read and that write.
- R9: `irq_level` equals the programmed level while the flag is set and the level is nonzero. It is zero otherwise.
- R10: `irq_arb` is {arbitration bit 3, `arb_lo`}. Reset clears arbitration bit 3, the level, the flag and prescaler bit 0.
- R11: The run bit keeps its value through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Prescaler count enable from the timebase |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, combinational from the address |
| arb_lo | input | 3 | Low three bits of the arbitration number |
| irq_level | output | 3 | Requested interrupt level, 0 means none |
| irq_arb | output | 4 | Arbitration number of the request |

## Verification
A sequencer stuck in the wrong state shows up on the next counter or prescaler write. The loaded value either fails to appear or appears when it should have been ignored, so a single readback exposes it. A lost or stale "seen" marker shows up in the cycle after the clearing write, as a flag bit and an `irq_level` that disagree with the expected result. Counting faults are exposed by sweeping every prescaler start value against tick runs that end before, at and after a wrap. Each run ends with a read of both counters against arithmetic totals.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [1:0] {
        WE_CLOSED     = 2'd0,
        WE_ARMED      = 2'd1,
        WE_COUNT_DONE = 2'd2
    } wen_state_t;

    typedef enum logic {
        FLG_UNSEEN = 1'b0,
        FLG_SEEN   = 1'b1
    } flag_state_t;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_COUNT = 2'd1;
    localparam logic [1:0] ADDR_PRESC = 2'd2;

    localparam int CTRL_RUN    = 0;
    localparam int CTRL_ARM    = 1;
    localparam int CTRL_FLAG   = 2;
    localparam int CTRL_LVL_LO = 4;
    localparam int CTRL_ARB3   = 7;

endpackage

// File: rtl/rtc_counter_chain.sv
module rtc_counter_chain #(
    parameter int PRE_W = 15,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             presc_load,
    input  logic [PRE_W-1:0] presc_wval,
    input  logic             cnt_load,
    input  logic [CNT_W-1:0] cnt_wval,
    output logic [PRE_W-1:0] presc,
    output logic [CNT_W-1:0] cnt,
    output logic             carry
);

    localparam logic [PRE_W-1:0] PRE_MAX = '1;

    logic             presc_lsb;
    logic [PRE_W-2:0] presc_upper;
    logic [PRE_W-1:0] presc_next;
    logic [CNT_W-1:0] cnt_next;

    assign presc = {presc_upper, presc_lsb};
    assign carry = advance && !presc_load && (presc == PRE_MAX);

    always_comb begin
        if (presc_load)
            presc_next = presc_wval;
        else if (advance)
            presc_next = presc + PRE_W'(1);
        else
            presc_next = presc;
    end

    always_comb begin
        if (cnt_load)
            cnt_next = cnt_wval;
        else if (carry)
            cnt_next = cnt + CNT_W'(1);
        else
            cnt_next = cnt;
    end

    // only the lowest prescaler bit has a defined reset value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            presc_lsb <= 1'b0;
        else
            presc_lsb <= presc_next[0];
    end

    always_ff @(posedge clk) begin
        presc_upper <= presc_next[PRE_W-1:1];
        cnt         <= cnt_next;
    end

endmodule

// File: rtl/rtc_wen_fsm.sv
module rtc_wen_fsm
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm_req,
    input  logic       cnt_wr,
    input  logic       presc_wr,
    output logic       cnt_load,
    output logic       presc_load,
    output wen_state_t state
);

    wen_state_t state_next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= WE_CLOSED;
        else
            state <= state_next;
    end

    always_comb begin
        state_next = state;
        unique case (state)
            WE_CLOSED:     if (arm_req)  state_next = WE_ARMED;
            WE_ARMED:      if (cnt_wr)   state_next = WE_COUNT_DONE;
            WE_COUNT_DONE: if (presc_wr) state_next = WE_CLOSED;
            default:                     state_next = WE_CLOSED;
        endcase
    end

    always_comb begin
        cnt_load   = 1'b0;
        presc_load = 1'b0;
        unique case (state)
            WE_CLOSED: ;
            WE_ARMED:      cnt_load = cnt_wr;
            WE_COUNT_DONE: begin
                cnt_load   = cnt_wr;
                presc_load = presc_wr;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rtc_flag_fsm.sv
module rtc_flag_fsm
    import rtc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_rd,
    input  logic        clr_req,
    input  logic        inc,
    output logic        flag,
    output flag_state_t state
);

    flag_state_t state_next;
    logic        flag_next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FLG_UNSEEN;
            flag  <= 1'b0;
        end else begin
            state <= state_next;
            flag  <= flag_next;
        end
    end

    always_comb begin
        state_next = state;
        if (inc) begin
            state_next = FLG_UNSEEN;
        end else begin
            unique case (state)
                FLG_UNSEEN: if (ctrl_rd && flag) state_next = FLG_SEEN;
                FLG_SEEN:   if (clr_req)         state_next = FLG_UNSEEN;
                default:                         state_next = FLG_UNSEEN;
            endcase
        end
    end

    always_comb begin
        flag_next = flag;
        if (inc)
            flag_next = 1'b1;
        else if (state == FLG_SEEN && clr_req)
            flag_next = 1'b0;
    end

endmodule

// File: rtl/rtc_chain.sv
module rtc_chain
    import rtc_pkg::*;
#(
    parameter int PRE_W  = 15,
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32,
    parameter int LVL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [2:0]        arb_lo,
    output logic [LVL_W-1:0]  irq_level,
    output logic [3:0]        irq_arb
);

    localparam int CTRL_LVL_HI = CTRL_LVL_LO + LVL_W - 1;

    logic             run_q;
    logic [LVL_W-1:0] level_q;
    logic             arb3_q;

    logic             ctrl_wr;
    logic             ctrl_rd;
    logic             advance;
    logic             carry;
    logic             cnt_load;
    logic             presc_load;
    logic             flag;
    logic [PRE_W-1:0] presc;
    logic [CNT_W-1:0] cnt;
    wen_state_t       wen_state;
    flag_state_t      flg_state;
    logic [DATA_W-1:0] ctrl_word;

    assign ctrl_wr = bus_wr && (bus_addr == ADDR_CTRL);
    assign ctrl_rd = bus_rd && (bus_addr == ADDR_CTRL);
    assign advance = run_q && tick_en;

    // run bit has no reset: it survives a reset pulse
    always_ff @(posedge clk) begin
        if (ctrl_wr)
            run_q <= bus_wdata[CTRL_RUN];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= '0;
            arb3_q  <= 1'b0;
        end else if (ctrl_wr) begin
            level_q <= bus_wdata[CTRL_LVL_HI:CTRL_LVL_LO];
            arb3_q  <= bus_wdata[CTRL_ARB3];
        end
    end

    rtc_wen_fsm u_wen (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_req    (ctrl_wr && bus_wdata[CTRL_ARM]),
        .cnt_wr     (bus_wr && (bus_addr == ADDR_COUNT)),
        .presc_wr   (bus_wr && (bus_addr == ADDR_PRESC)),
        .cnt_load   (cnt_load),
        .presc_load (presc_load),
        .state      (wen_state)
    );

    rtc_counter_chain #(
        .PRE_W (PRE_W),
        .CNT_W (CNT_W)
    ) u_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .advance    (advance),
        .presc_load (presc_load),
        .presc_wval (bus_wdata[PRE_W-1:0]),
        .cnt_load   (cnt_load),
        .cnt_wval   (bus_wdata[CNT_W-1:0]),
        .presc      (presc),
        .cnt        (cnt),
        .carry      (carry)
    );

    rtc_flag_fsm u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_rd (ctrl_rd),
        .clr_req (ctrl_wr && !bus_wdata[CTRL_FLAG]),
        .inc     (carry),
        .flag    (flag),
        .state   (flg_state)
    );

    always_comb begin
        ctrl_word = '0;
        ctrl_word[CTRL_RUN]                = run_q;
        ctrl_word[CTRL_FLAG]               = flag;
        ctrl_word[CTRL_LVL_HI:CTRL_LVL_LO] = level_q;
        ctrl_word[CTRL_ARB3]               = arb3_q;
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_CTRL:  bus_rdata = ctrl_word;
            ADDR_COUNT: bus_rdata = DATA_W'(cnt);
            ADDR_PRESC: bus_rdata = DATA_W'(presc);
            default:    bus_rdata = '0;
        endcase
    end

    assign irq_level = (flag && (level_q != '0)) ? level_q : '0;
    assign irq_arb   = {arb3_q, arb_lo};

endmodule

// File: rtl/rtc_chain_chk.sv
module rtc_chain_chk
    import rtc_pkg::*;
#(
    parameter int PRE_W  = 15,
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32,
    parameter int LVL_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              advance,
    input logic              carry,
    input logic              presc_load,
    input logic              cnt_load,
    input logic [PRE_W-1:0]  presc,
    input logic [CNT_W-1:0]  cnt,
    input logic              flag,
    input logic [1:0]        wen_state,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [1:0]        bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [LVL_W-1:0]  irq_level
);

    // R1
    presc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !presc_load) |=> (presc == $past(presc)));

    // R2
    wrap_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (carry && !cnt_load) |=> ((cnt == $past(cnt) + CNT_W'(1)) && flag && (presc == '0)));

    // R3
    closed_count_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_COUNT && wen_state == 2'(WE_CLOSED) && !carry)
        |=> (cnt == $past(cnt)));

    // R6
    arm_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_CTRL) |-> !bus_rdata[CTRL_ARM]);

    // R7
    flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(bus_wr && bus_addr == ADDR_CTRL && !bus_wdata[CTRL_FLAG]));

    // R9
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != '0) |-> flag);

endmodule

bind rtc_chain rtc_chain_chk #(
    .PRE_W  (PRE_W),
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W),
    .LVL_W  (LVL_W)
) u_rtc_chain_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .advance    (advance),
    .carry      (carry),
    .presc_load (presc_load),
    .cnt_load   (cnt_load),
    .presc      (presc),
    .cnt        (cnt),
    .flag       (flag),
    .wen_state  (wen_state),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq_level  (irq_level)
);

// File: tb/test_rtc_chain.sv
`timescale 1ns/1ps
module test_rtc_chain;

    localparam int PW   = 4;
    localparam int PMOD = 1 << PW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  arb_lo = 3'd0;
    logic [2:0]  irq_level;
    logic [3:0]  irq_arb;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    bit         s_run = 1'b0;
    logic [2:0] s_lvl = 3'd0;
    bit         s_arb3 = 1'b0;

    always #2.5 clk = ~clk;

    rtc_chain #(.PRE_W(PW)) i_rtc_chain (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .arb_lo(arb_lo), .irq_level(irq_level), .irq_arb(irq_arb)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ctl(bit arm, bit keep_flag);
        return {24'd0, s_arb3, s_lvl, 1'b0, keep_flag, arm, s_run};
    endfunction

    task automatic bus_write(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        s_lvl = 3'd0; s_arb3 = 1'b0;
    endtask

    task automatic ticks(int n);
        @(negedge clk); tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic load_chain(logic [31:0] c, logic [31:0] p);
        bus_write(2'd0, ctl(1'b1, 1'b1));
        bus_write(2'd1, c);
        bus_write(2'd2, p);
    endtask

    initial begin
        logic [31:0] rd;
        logic [31:0] exp_c;
        int total;
        logic [31:0] bases [3];
        bases[0] = 32'h0000_0000; bases[1] = 32'h7FFF_FFFF; bases[2] = 32'hFFFF_FFFE;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        bus_read(2'd0, rd);
        chk("R10 ctrl flag/level/arb3 after reset", rd & 32'hF4, 32'h0);
        bus_read(2'd2, rd);
        chk("R10 prescaler bit0 after reset", {31'd0, rd[0]}, 32'd0);
        chk("R10 irq_level after reset", {29'd0, irq_level}, 32'd0);

        // R11 run survives reset
        s_run = 1'b1; bus_write(2'd0, ctl(1'b0, 1'b1));
        pulse_reset();
        bus_read(2'd0, rd);
        chk("R11 run=1 kept through reset", {31'd0, rd[0]}, 32'd1);
        s_run = 1'b0; bus_write(2'd0, ctl(1'b0, 1'b1));
        pulse_reset();
        bus_read(2'd0, rd);
        chk("R11 run=0 kept through reset", {31'd0, rd[0]}, 32'd0);
        s_run = 1'b1; bus_write(2'd0, ctl(1'b0, 1'b1));

        // R4 guarded load, R6 arm reads zero
        bus_write(2'd0, ctl(1'b1, 1'b1));
        bus_read(2'd0, rd);
        chk("R6 arm bit reads zero", {31'd0, rd[1]}, 32'd0);
        bus_write(2'd1, 32'h1234_5678);
        bus_write(2'd2, 32'd3);
        bus_read(2'd1, rd); chk("R4 counter loaded", rd, 32'h1234_5678);
        bus_read(2'd2, rd); chk("R4 prescaler loaded", rd, 32'd3);

        // R3 writes while closed are ignored
        bus_write(2'd1, 32'hAAAA_5555);
        bus_write(2'd2, 32'd9);
        bus_read(2'd1, rd); chk("R3 closed counter write ignored", rd, 32'h1234_5678);
        bus_read(2'd2, rd); chk("R3 closed prescaler write ignored", rd, 32'd3);

        // R5 ordering and re-arm ignored
        bus_write(2'd0, ctl(1'b1, 1'b1));
        bus_write(2'd2, 32'd7);
        bus_read(2'd2, rd); chk("R5 early prescaler write ignored", rd, 32'd3);
        bus_write(2'd1, 32'hCAFE_0001);
        bus_read(2'd1, rd); chk("R5 counter accepted while armed", rd, 32'hCAFE_0001);
        bus_write(2'd0, ctl(1'b1, 1'b1));
        bus_write(2'd2, 32'd7);
        bus_read(2'd2, rd); chk("R5 prescaler accepted after counter", rd, 32'd7);
        bus_write(2'd1, 32'h0BAD_0BAD);
        bus_read(2'd1, rd); chk("R4 latch closed by prescaler write", rd, 32'hCAFE_0001);
        bus_write(2'd2, 32'd1);
        bus_read(2'd2, rd); chk("R4 prescaler closed after sequence", rd, 32'd7);

        // R1 no advance while stopped
        s_run = 1'b0; bus_write(2'd0, ctl(1'b0, 1'b1));
        ticks(20);
        bus_read(2'd2, rd); chk("R1 prescaler holds when stopped", rd, 32'd7);
        bus_read(2'd1, rd); chk("R1 counter holds when stopped", rd, 32'hCAFE_0001);
        s_run = 1'b1; bus_write(2'd0, ctl(1'b0, 1'b1));

        // R1/R2 sweep over every start value and run lengths around a wrap
        for (int b = 0; b < 3; b++) begin
            for (int s = 0; s < PMOD; s++) begin
                for (int k = 0; k < 4; k++) begin
                    int n;
                    n = (k == 0) ? 1 : (k == 1) ? (PMOD - s) : (k == 2) ? (PMOD - s + 1) : 37;
                    load_chain(bases[b], 32'(s));
                    ticks(n);
                    total = s + n;
                    exp_c = bases[b] + 32'(total / PMOD);
                    bus_read(2'd2, rd); chk("R1 prescaler after ticks", rd, 32'(total % PMOD));
                    bus_read(2'd1, rd); chk("R2 counter after ticks", rd, exp_c);
                end
            end
        end

        // R2 flag sets on wrap; R7 guarded clear
        load_chain(32'd0, 32'(PMOD - 1));
        bus_read(2'd0, rd);
        if (rd[2]) bus_write(2'd0, ctl(1'b0, 1'b0));
        bus_read(2'd0, rd); chk("R7 flag cleared after read", {31'd0, rd[2]}, 32'd0);
        ticks(1);
        bus_read(2'd0, rd); chk("R2 flag set by wrap", {31'd0, rd[2]}, 32'd1);
        bus_write(2'd0, ctl(1'b0, 1'b1));
        bus_read(2'd0, rd); chk("R7 write of 1 leaves flag", {31'd0, rd[2]}, 32'd1);
        bus_write(2'd0, ctl(1'b0, 1'b0));
        bus_read(2'd0, rd); chk("R7 clear after read succeeds", {31'd0, rd[2]}, 32'd0);

        load_chain(32'd0, 32'(PMOD - 1));
        ticks(1);
        bus_write(2'd0, ctl(1'b0, 1'b0));
        bus_read(2'd0, rd); chk("R7 clear without prior read ignored", {31'd0, rd[2]}, 32'd1);

        // R8 increment between read and clear rejects the clear
        load_chain(32'd5, 32'(PMOD - 1));
        bus_read(2'd0, rd);
        ticks(1);
        bus_write(2'd0, ctl(1'b0, 1'b0));
        bus_read(2'd0, rd); chk("R8 clear rejected after increment", {31'd0, rd[2]}, 32'd1);
        bus_read(2'd1, rd); chk("R8 counter advanced", rd, 32'd6);

        // R9 interrupt level
        s_lvl = 3'd5; bus_write(2'd0, ctl(1'b0, 1'b1));
        #1 chk("R9 irq at level 5", {29'd0, irq_level}, 32'd5);
        s_lvl = 3'd0; bus_write(2'd0, ctl(1'b0, 1'b1));
        #1 chk("R9 level 0 gives no irq", {29'd0, irq_level}, 32'd0);
        s_lvl = 3'd6; bus_write(2'd0, ctl(1'b0, 1'b1));
        bus_read(2'd0, rd);
        bus_write(2'd0, ctl(1'b0, 1'b0));
        #1 chk("R9 no irq once flag cleared", {29'd0, irq_level}, 32'd0);
        bus_read(2'd0, rd); chk("R6 control readback", rd & 32'hF5, 32'h61);

        // R10 arbitration number
        arb_lo = 3'b010; s_arb3 = 1'b1; bus_write(2'd0, ctl(1'b0, 1'b1));
        #1 chk("R10 irq_arb composition", {28'd0, irq_arb}, 32'hA);
        pulse_reset();
        #1 chk("R10 reset clears arb bit 3", {28'd0, irq_arb}, 32'h2);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule